// File: doc/BRIEF.md
# Load Stride Learning Table

This block is a small direct-mapped table that learns, for each static load instruction, whether the load walks memory with a constant address step. Every load presents its program counter and effective address on the lookup port. The table trains the entry that belongs to that PC. One cycle later it reports four things:

- whether the PC hit an existing entry;
- the stride now held for it;
- whether that stride is trusted enough to start vectorizing the load;
- the recorded end-of-chain PC, if one exists.

A second port is used by the vectorization logic. When a load that depends on a striding load is vectorized, this port writes the dependent load's PC into the striding load's entry as its terminator. Later lookups of the striding load return that terminator, so that runahead knows where to stop.

Each entry holds:

- a valid bit and a tag;
- the last address seen;
- the stride;
- a two-bit confidence counter;
- a terminator valid bit and the terminator PC.

A different PC that maps to the same slot overwrites the entry. No other replacement policy is used.

Top module: `stride_table`

## Requirements
- R1: The entry index is `lk_pc[IDX_W+1:2]`. The tag is the rest of the PC, bits `[PC_W-1:IDX_W+2]` together with bits `[1:0]`. A lookup hits when the indexed entry is valid and its tag is equal. `rsp_valid` is high exactly one cycle after each cycle in which `lk_valid` is high.
- R2: A lookup that misses allocates the entry. The entry stores the tag and the address, with stride 0, counter 0 and no terminator. The response shows `rsp_hit`=0, `rsp_stride`=0, `rsp_capture`=0, `rsp_term_valid`=0 and `rsp_term_pc`=0.
- R3: On a hit, the new stride is the current address minus the stored last address, taken modulo 2^ADDR_W. Negative strides are therefore two's complement. The stored last address becomes the current address.
- R4: On a hit where the new stride equals the stored stride, the counter increments and saturates at 3. On a mismatch, the counter goes to 0 and the stored stride is replaced by the new one. `rsp_stride` reports the stride held after the update.
- R5: `rsp_capture` is 1 exactly when the lookup hit, the counter after the update is 3, and the stride after the update is nonzero. A zero stride never captures.
- R6: When `upd_valid` is high and `upd_pc` hits a valid entry under the rule of R1, that entry's terminator is set to `upd_term_pc` and marked valid. Later hits on that entry report it through `rsp_term_valid` and `rsp_term_pc`.
- R7: An update whose PC does not hit leaves every entry unchanged. This covers an invalid slot and a slot holding another tag.
- R8: When a miss overwrites an entry that held a terminator, the terminator is cleared. `rsp_term_pc` is 0 whenever `rsp_term_valid` is 0.
- R9: After reset, every entry is invalid and all response outputs are 0. In a cycle that follows no lookup, all response outputs are 0.
- R10: A lookup and an update in the same cycle on the same index are resolved as follows. If the lookup hits, both take effect: the response carries the terminator held before the update, and the next hit shows the new terminator. If the lookup misses, the allocation wins and the update is dropped.
- R11: A lookup or update changes only the indexed entry. Other entries keep their stride, counter and terminator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Load lookup request |
| lk_pc | input | PC_W | PC of the looked-up load |
| lk_addr | input | ADDR_W | Effective address of the load |
| upd_valid | input | 1 | Terminator write request |
| upd_pc | input | PC_W | PC of the initiating striding load |
| upd_term_pc | input | PC_W | PC of the final dependent load |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup found its entry |
| rsp_capture | output | 1 | Confident nonzero stride |
| rsp_stride | output | ADDR_W | Stride held after training |
| rsp_term_valid | output | 1 | A terminator is recorded |
| rsp_term_pc | output | PC_W | Recorded terminator PC |

## Verification
The training path is driven with several address streams, each separating a different part of the behaviour:

- A steady positive stride shows that capture appears on the fourth hit and stays.
- A stride break shows that the counter restarts and the stored stride is replaced.
- A repeated address shows that a saturated zero stride is kept from capturing.
- A descending stream shows the two's complement difference.

Aliasing PCs on one index separate a tag hit from an index hit. They also show that an overwrite drops the terminator while a neighbouring slot keeps its training. Terminator writes are tried against a hit, against a mismatched tag, and in the same cycle as both a hitting and an allocating lookup, which tells apart the two outcomes of R10.

// File: rtl/stride_table.sv
module stride_table #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int CONF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [PC_W-1:0]   upd_term_pc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_capture,
  output logic [ADDR_W-1:0] rsp_stride,
  output logic              rsp_term_valid,
  output logic [PC_W-1:0]   rsp_term_pc
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  logic              e_v    [ENTRIES];
  logic [TAG_W-1:0]  e_tag  [ENTRIES];
  logic [ADDR_W-1:0] e_last [ENTRIES];
  logic [ADDR_W-1:0] e_str  [ENTRIES];
  logic [CONF_W-1:0] e_cnt  [ENTRIES];
  logic              e_tv   [ENTRIES];
  logic [PC_W-1:0]   e_tp   [ENTRIES];

  logic [IDX_W-1:0]  l_idx, u_idx;
  logic [TAG_W-1:0]  l_tag, u_tag;
  logic              l_hit, u_hit, u_blocked, l_match;
  logic [ADDR_W-1:0] l_delta, n_str;
  logic [CONF_W-1:0] n_cnt;

  assign l_idx = lk_pc[IDX_W+1:2];
  assign l_tag = {lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0]};
  assign u_idx = upd_pc[IDX_W+1:2];
  assign u_tag = {upd_pc[PC_W-1:IDX_W+2], upd_pc[1:0]};

  assign l_hit   = e_v[l_idx] && (e_tag[l_idx] == l_tag);
  assign l_delta = lk_addr - e_last[l_idx];
  assign l_match = (l_delta == e_str[l_idx]);
  assign n_str   = l_match ? e_str[l_idx] : l_delta;
  assign n_cnt   = !l_match ? '0 :
                   (e_cnt[l_idx] == CONF_MAX) ? CONF_MAX : e_cnt[l_idx] + 1'b1;

  assign u_hit     = upd_valid && e_v[u_idx] && (e_tag[u_idx] == u_tag);
  assign u_blocked = lk_valid && !l_hit && (l_idx == u_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_v[i]    <= 1'b0;
        e_tag[i]  <= '0;
        e_last[i] <= '0;
        e_str[i]  <= '0;
        e_cnt[i]  <= '0;
        e_tv[i]   <= 1'b0;
        e_tp[i]   <= '0;
      end
    end else begin
      if (lk_valid) begin
        e_last[l_idx] <= lk_addr;
        if (l_hit) begin
          e_str[l_idx] <= n_str;
          e_cnt[l_idx] <= n_cnt;
        end else begin
          e_v[l_idx]   <= 1'b1;
          e_tag[l_idx] <= l_tag;
          e_str[l_idx] <= '0;
          e_cnt[l_idx] <= '0;
          e_tv[l_idx]  <= 1'b0;
          e_tp[l_idx]  <= '0;
        end
      end
      if (u_hit && !u_blocked) begin
        e_tv[u_idx] <= 1'b1;
        e_tp[u_idx] <= upd_term_pc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lk_valid) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_capture    <= 1'b0;
      rsp_stride     <= '0;
      rsp_term_valid <= 1'b0;
      rsp_term_pc    <= '0;
    end else begin
      rsp_valid      <= 1'b1;
      rsp_hit        <= l_hit;
      rsp_capture    <= l_hit && (n_cnt == CONF_MAX) && (n_str != '0);
      rsp_stride     <= l_hit ? n_str : '0;
      rsp_term_valid <= l_hit && e_tv[l_idx];
      rsp_term_pc    <= l_hit ? e_tp[l_idx] : '0;
    end
  end
endmodule

// File: rtl/stride_table_chk.sv
module stride_table_chk #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_capture,
  input logic [ADDR_W-1:0] rsp_stride,
  input logic              rsp_term_valid,
  input logic [PC_W-1:0]   rsp_term_pc
);
  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R1
  rsp_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  // R2
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_capture && !rsp_term_valid && rsp_stride == '0));
  // R5
  capture_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_capture |-> (rsp_hit && rsp_stride != '0));
  // R8
  term_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_term_valid |-> rsp_term_pc == '0);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_capture && rsp_stride == '0 && !rsp_term_valid));
endmodule

bind stride_table stride_table_chk #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_capture(rsp_capture), .rsp_stride(rsp_stride),
  .rsp_term_valid(rsp_term_valid), .rsp_term_pc(rsp_term_pc)
);

// File: tb/stride_table_bench.sv
module stride_table_bench;
  localparam int PC_W = 32, ADDR_W = 32, IDX_W = 4, N = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, upd_valid = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0, upd_term_pc = '0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic rsp_valid, rsp_hit, rsp_capture, rsp_term_valid;
  logic [ADDR_W-1:0] rsp_stride;
  logic [PC_W-1:0] rsp_term_pc;

  always #5 clk = ~clk;

  stride_table #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CONF_W(2)) u_stride_table (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_addr(lk_addr),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_term_pc(upd_term_pc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_capture(rsp_capture),
    .rsp_stride(rsp_stride), .rsp_term_valid(rsp_term_valid), .rsp_term_pc(rsp_term_pc));

  typedef struct {
    logic hit; logic cap; logic [ADDR_W-1:0] str; logic tv; logic [PC_W-1:0] tp; string req;
  } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;

  logic              m_v [N];
  logic [PC_W-1:0]   m_pc [N];
  logic [ADDR_W-1:0] m_last [N], m_str [N];
  int                m_cnt [N];
  logic              m_tv [N];
  logic [PC_W-1:0]   m_tp [N];

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  task automatic step(input logic lv, input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a,
                      input logic uv, input logic [PC_W-1:0] upc, input logic [PC_W-1:0] ut,
                      input string req);
    exp_t e;
    int li, ui;
    logic lhit, uhit;
    @(negedge clk);
    lk_valid = lv; lk_pc = pc; lk_addr = a;
    upd_valid = uv; upd_pc = upc; upd_term_pc = ut;
    li = idx_of(pc); ui = idx_of(upc);
    lhit = m_v[li] && m_pc[li] == pc;
    uhit = uv && m_v[ui] && m_pc[ui] == upc;
    if (lv) begin
      e.req = req;
      if (lhit) begin
        logic [ADDR_W-1:0] d;
        d = a - m_last[li];
        if (d == m_str[li]) m_cnt[li] = (m_cnt[li] == 3) ? 3 : m_cnt[li] + 1;
        else begin m_cnt[li] = 0; m_str[li] = d; end
        e.hit = 1; e.str = m_str[li];
        e.cap = (m_cnt[li] == 3) && (m_str[li] != 0);
        e.tv = m_tv[li]; e.tp = m_tp[li];
      end else begin
        m_v[li] = 1; m_pc[li] = pc; m_str[li] = 0; m_cnt[li] = 0; m_tv[li] = 0; m_tp[li] = 0;
        e.hit = 0; e.cap = 0; e.str = 0; e.tv = 0; e.tp = 0;
      end
      m_last[li] = a;
      sb.push_back(e);
    end
    if (uhit && !(lv && !lhit && li == ui)) begin
      m_tv[ui] = 1; m_tp[ui] = ut;
    end
  endtask

  task automatic ld(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a, input string req);
    step(1'b1, pc, a, 1'b0, '0, '0, req);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, '0, '0, "");
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R1 response without lookup: actual rsp_valid=1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_hit !== e.hit || rsp_capture !== e.cap || rsp_stride !== e.str ||
            rsp_term_valid !== e.tv || rsp_term_pc !== e.tp) begin
          errors++;
          $display("FAIL %s: actual hit=%0b cap=%0b str=%0h tv=%0b tp=%0h expected hit=%0b cap=%0b str=%0h tv=%0b tp=%0h",
                   e.req, rsp_hit, rsp_capture, rsp_stride, rsp_term_valid, rsp_term_pc,
                   e.hit, e.cap, e.str, e.tv, e.tp);
        end
      end
    end
  end

  localparam logic [PC_W-1:0] PA = 32'h1000, PB = 32'h1004, PC = 32'h1008, PE = 32'h1040;

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_pc[i] = 0; m_last[i] = 0; m_str[i] = 0; m_cnt[i] = 0; m_tv[i] = 0; m_tp[i] = 0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_capture !== 0 || rsp_stride !== 0 ||
        rsp_term_valid !== 0 || rsp_term_pc !== 0) begin
      errors++;
      $display("FAIL R9 reset outputs: actual valid=%0b cap=%0b str=%0h expected all 0",
               rsp_valid, rsp_capture, rsp_stride);
    end
    rst_n = 1'b1;

    // R2 R3 R4 R5: steady stride of 8 on PA
    for (int k = 0; k < 7; k++) ld(PA, 32'd100 + 32'(8 * k), "R4_steady");
    // R4: stride break then retrain
    for (int k = 1; k <= 5; k++) ld(PA, 32'd148 + 32'(10 * k), "R4_break");
    // R5: zero stride never captures
    for (int k = 0; k < 6; k++) ld(PB, 32'h500, "R5_zero");
    // R3: descending stream
    for (int k = 0; k < 6; k++) ld(PC, 32'd1000 - 32'(8 * k), "R3_negative");
    // R9: idle cycle produces no response
    idle();
    checks++;
    @(negedge clk);
    if (rsp_valid !== 0 || rsp_capture !== 0) begin
      errors++;
      $display("FAIL R9 idle: actual valid=%0b expected 0", rsp_valid);
    end
    // R6: terminator write and readback
    step(1'b0, '0, '0, 1'b1, PA, 32'h2040, "");
    ld(PA, 32'd258, "R6_term");
    // R7: update with aliasing tag and with empty slot ignored
    step(1'b0, '0, '0, 1'b1, PE, 32'h3000, "");
    step(1'b0, '0, '0, 1'b1, 32'h10F0, 32'h3004, "");
    ld(PA, 32'd268, "R7_ignored");
    ld(32'h10F0, 32'd4, "R7_empty_slot");
    // R10: same-cycle update with hitting lookup
    step(1'b1, PA, 32'd278, 1'b1, PA, 32'h2080, "R10_hit_old");
    ld(PA, 32'd288, "R10_hit_new");
    // R10: update races an allocating lookup on same index
    step(1'b1, PE, 32'd900, 1'b1, PA, 32'h20C0, "R10_alloc");
    ld(PE, 32'd904, "R10_alloc_wins");
    // R8 R1: overwrite by alias, original PA returns as miss with no terminator
    ld(PA, 32'd300, "R8_realloc");
    ld(PA, 32'd308, "R8_cleared");
    // R11: untouched neighbour keeps its trained state
    ld(PC, 32'd944, "R11_neighbour");
    ld(PB, 32'h500, "R11_zero_kept");
    idle(); idle(); idle();
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses: actual pending=%0d expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule